// File: doc/BRIEF.md
# Peripheral Interrupt Mapping Controller

This block collects 32 level-sensitive, active-high peripheral interrupt requests and presents them on 9 general-purpose request lines into a core event controller. Channel 0 feeds core level 7, which has the highest priority. Channel 8 feeds core level 15, which has the lowest. Each source passes through its own enable bit. It is then steered by a 4-bit selector to one channel, so the selector value also fixes the source's effective priority. All enabled, active sources that share a channel are ORed together, with no ordering among them.

A separate per-source wake mask drives a wake line that the power controller uses to leave idle or power-down. This line ignores the enable bits. A small word-addressed register port gives access to the enable, wake-mask and selector registers. It also returns the live request inputs as a read-only status word. The channel and wake outputs are registered, so a change takes one clock to appear.

Top module: `irq_route_top`

## Requirements
- R1: After reset, `ch_o` and `wake_o` are 0. The enable register (address 0) and the wake-mask register (address 1) read 0. Every source s has selector min(s/4, 8).
- R2: A source whose enable bit (bit s of address 0) is 0 never asserts any `ch_o` bit, whatever its request level.
- R3: An enabled, active source whose selector v is between 0 and 8 asserts exactly `ch_o[v]`. Bit 0 corresponds to core level 7 and bit 8 to level 15.
- R4: A selector value from 9 to 15 routes its source to no channel.
- R5: `ch_o[c]` is the OR of all enabled, active sources whose selector equals c.
- R6: `ch_o` reflects the request inputs and configuration of the previous clock edge, a latency of one cycle.
- R7: One cycle after any clock edge, `wake_o` equals the OR over s of `irq_i[s]` AND wake-mask bit s. The value is taken at that edge and is independent of the enable register.
- R8: Address 2 reads the current `irq_i` regardless of the enable bits. Writes to address 2 change no register.
- R9: The selector for source s sits in the register at address 4 + s/8, bits [4*(s%8)+3 : 4*(s%8)]. Writes take effect at the next clock edge and read back unchanged. Addresses 3 and 8 to 15 read 0 and ignore writes.
- R10: Changing one source's selector does not disturb any channel whose contributing sources are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Peripheral request levels, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` (combinational) |
| ch_o | output | 9 | Requests to core levels 7..15, bit 0 = level 7 |
| wake_o | output | 1 | Wake request for idle or power-down exit |

## Verification
A corrupted selector shows up at the ports as a request on the wrong channel, or on no channel, one clock after the source goes active. The same selector word read back through its register also exposes it at once. A stuck enable or wake-mask bit shows as a channel or wake line that ignores its source. The sweep visits every source with every selector value, so each field-decode error reaches `ch_o` within two cycles of the write. Random request patterns over a mixed mapping then expose wrong OR grouping across shared channels.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_SRC  = DATA_W;
  localparam int NUM_CH   = 9;
  localparam int SEL_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int FLD_PER  = DATA_W / SEL_W;
  localparam int NUM_MAP  = NUM_SRC / FLD_PER;
  localparam int SRC_GRP  = 4;

  localparam logic [ADDR_W-1:0] A_ENA   = 4'd0;
  localparam logic [ADDR_W-1:0] A_WAKE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd2;
  localparam int                MAP_BASE = 4;

  typedef logic [NUM_SRC-1:0][SEL_W-1:0] sel_arr_t;

  function automatic logic [SEL_W-1:0] default_sel(input int src);
    int v;
    v = src / SRC_GRP;
    if (v > NUM_CH - 1) v = NUM_CH - 1;
    return SEL_W'(v);
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] irq_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_SRC-1:0] ena_o,
  output logic [NUM_SRC-1:0] wmask_o,
  output sel_arr_t           sel_o
);
  logic [NUM_SRC-1:0] ena_q, wmask_q;
  sel_arr_t           sel_q;
  logic [NUM_MAP-1:0][DATA_W-1:0] map_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q   <= '0;
      wmask_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_ENA)  ena_q   <= wdata_i;
      if (addr_i == A_WAKE) wmask_q <= wdata_i;
    end
  end

  for (genvar r = 0; r < NUM_MAP; r++) begin : g_map
    localparam logic [ADDR_W-1:0] A_R = ADDR_W'(MAP_BASE + r);
    for (genvar f = 0; f < FLD_PER; f++) begin : g_fld
      localparam int S = r * FLD_PER + f;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sel_q[S] <= default_sel(S);
        else if (wr_en_i && addr_i == A_R) sel_q[S] <= wdata_i[f*SEL_W +: SEL_W];
      end
      assign map_word[r][f*SEL_W +: SEL_W] = sel_q[S];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_ENA)  rdata_o = ena_q;
    if (addr_i == A_WAKE) rdata_o = wmask_q;
    if (addr_i == A_STAT) rdata_o = irq_i;
    for (int r = 0; r < NUM_MAP; r++)
      if (addr_i == ADDR_W'(MAP_BASE + r)) rdata_o = map_word[r];
  end

  assign ena_o   = ena_q;
  assign wmask_o = wmask_q;
  assign sel_o   = sel_q;

  // R8: the status address never alters stored configuration
  a_r8_stat_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_STAT) |=> ($stable(ena_q) && $stable(wmask_q) && $stable(sel_q)));
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
  import irq_route_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] ena_i,
  input  sel_arr_t           sel_i,
  output logic [NUM_CH-1:0]  ch_o
);
  logic [NUM_SRC-1:0]              live;
  logic [NUM_CH-1:0][NUM_SRC-1:0]  route;
  logic [NUM_CH-1:0]               hit;
  logic [NUM_CH-1:0]               ch_q;

  assign live = irq_i & ena_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign route[c][s] = (sel_i[s] == SEL_W'(c));
    end
    assign hit[c] = |(live & route[c]);
  end

  // registered so a selector rewrite cannot glitch other channels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch_q <= '0;
    else         ch_q <= hit;
  end

  assign ch_o = ch_q;
endmodule

// File: rtl/irq_route_wake.sv
module irq_route_wake
  import irq_route_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] wmask_i,
  output logic               wake_o
);
  logic wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= |(irq_i & wmask_i);
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0]  ch_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] ena_w, wmask_w;
  sel_arr_t           sel_w;

  irq_route_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .irq_i,
    .rdata_o, .ena_o(ena_w), .wmask_o(wmask_w), .sel_o(sel_w)
  );

  irq_route_xbar u_xbar (
    .clk_i, .rst_ni, .irq_i, .ena_i(ena_w), .sel_i(sel_w), .ch_o
  );

  irq_route_wake u_wake (
    .clk_i, .rst_ni, .irq_i, .wmask_i(wmask_w), .wake_o
  );

  // R2: nothing enabled and active means no channel next cycle
  a_r2_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_i & ena_w) == '0) |=> (ch_o == '0));

  // R3: each source drives at most one channel
  a_r3_one_channel_each: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(ch_o) <= $countones($past(irq_i & ena_w))));

  // R7: wake follows masked requests, ignoring enables
  a_r7_wake_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_i & wmask_w)) |=> wake_o);
  a_r7_wake_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(irq_i & wmask_w)) |=> !wake_o);

  // R10: unchanged inputs and mapping keep channels steady
  a_r10_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(irq_i) && $stable(ena_w) && $stable(sel_w)) |=> $stable(ch_o));
endmodule

// File: tb/irq_route_top_bench.sv
module irq_route_top_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  ch;
  logic        wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] ena_s, wm_s;
  int          sel_s [32];

  always #10 clk = ~clk;

  irq_route_top u_irq_route_top (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ch_o(ch), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #2 d = rdata;
  endtask

  function automatic logic [31:0] map_word(input int r);
    logic [31:0] w = '0;
    for (int f = 0; f < 8; f++) w[f*4 +: 4] = 4'(sel_s[r*8+f]);
    return w;
  endfunction

  function automatic logic [8:0] exp_ch(input logic [31:0] rq);
    logic [8:0] e = '0;
    for (int s = 0; s < 32; s++)
      if (rq[s] && ena_s[s] && sel_s[s] < 9) e[sel_s[s]] = 1'b1;
    return e;
  endfunction

  task automatic set_sel(input int s, input int v);
    sel_s[s] = v;
    wr(4'(4 + s/8), map_word(s/8));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    ena_s = '0; wm_s = '0;
    for (int s = 0; s < 32; s++) sel_s[s] = (s/4 > 8) ? 8 : s/4;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ch", 32'(ch), 32'h0);
    chk("R1 wake", 32'(wake), 32'h0);
    rd(4'd0, d); chk("R1 enable reg", d, 32'h0);
    rd(4'd1, d); chk("R1 wake mask reg", d, 32'h0);
    for (int r = 0; r < 4; r++) begin
      rd(4'(4 + r), d); chk("R1 default selectors", d, map_word(r));
    end

    // R2 all requests high, nothing enabled
    irq = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    chk("R2 masked sources", 32'(ch), 32'h0);
    chk("R7 no wake without mask", 32'(wake), 32'h0);
    rd(4'd2, d); chk("R8 status ignores enables", d, 32'hFFFF_FFFF);

    // R3/R4 sweep every source against every selector value
    for (int s = 0; s < 32; s++) begin
      ena_s = 32'h1 << s;
      wr(4'd0, ena_s);
      for (int v = 0; v < 16; v++) begin
        set_sel(s, v);
        @(negedge clk);
        chk(v < 9 ? "R3 route" : "R4 unrouted", 32'(ch), 32'(exp_ch(irq)));
      end
    end

    // R9 readback of packing
    for (int r = 0; r < 4; r++) begin
      rd(4'(4 + r), d); chk("R9 selector readback", d, map_word(r));
    end

    // R6 latency
    for (int s = 0; s < 32; s++) sel_s[s] = (s * 7 + 3) % 16;
    for (int r = 0; r < 4; r++) wr(4'(4 + r), map_word(r));
    ena_s = 32'hFFFF_FFFF; wr(4'd0, ena_s);
    irq = '0;
    repeat (2) @(negedge clk);
    chk("R6 idle", 32'(ch), 32'h0);
    irq = 32'h1;
    #2 chk("R6 not before edge", 32'(ch), 32'h0);
    @(negedge clk);
    chk("R6 after one edge", 32'(ch), 32'(exp_ch(irq)));

    // R5/R7 random patterns over mixed mapping, enables and wake mask
    ena_s = 32'hA5F0_3C5A; wr(4'd0, ena_s);
    wm_s  = 32'h0F0F_1234; wr(4'd1, wm_s);
    rd(4'd0, d); chk("R9 enable readback", d, ena_s);
    rd(4'd1, d); chk("R9 wake mask readback", d, wm_s);
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      irq = lfsr & {lfsr[15:0], lfsr[31:16]};
      @(negedge clk);
      chk("R5 shared OR", 32'(ch), 32'(exp_ch(irq)));
      chk("R7 wake", 32'(wake), 32'(|(irq & wm_s)));
    end

    // R5 all sources on one channel
    for (int s = 0; s < 32; s++) sel_s[s] = 3;
    for (int r = 0; r < 4; r++) wr(4'(4 + r), 32'h3333_3333);
    ena_s = 32'hFFFF_FFFF; wr(4'd0, ena_s);
    irq = 32'h8000_0001;
    @(negedge clk);
    chk("R5 two on channel 3", 32'(ch), 32'h8);
    irq = 32'h0001_0000;
    @(negedge clk);
    chk("R5 one on channel 3", 32'(ch), 32'h8);

    // R7 wake independent of enable register
    ena_s = '0; wr(4'd0, ena_s);
    wm_s = 32'h0000_F00F; wr(4'd1, wm_s);
    irq = 32'h2;
    @(negedge clk);
    chk("R7 wake while disabled", 32'(wake), 32'h1);
    chk("R2 disabled no channel", 32'(ch), 32'h0);
    irq = 32'h20;
    @(negedge clk);
    chk("R7 wake off for unmasked source", 32'(wake), 32'h0);

    // R8/R9 writes to status and unmapped addresses are ignored
    wr(4'd2, 32'hDEAD_BEEF);
    wr(4'd3, 32'h1234_5678);
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd0, d); chk("R8 enable untouched", d, ena_s);
    rd(4'd1, d); chk("R8 wake mask untouched", d, wm_s);
    rd(4'd2, d); chk("R8 status live", d, irq);
    rd(4'd3, d); chk("R9 hole reads zero", d, 32'h0);
    rd(4'd9, d); chk("R9 high hole reads zero", d, 32'h0);
    for (int r = 0; r < 4; r++) begin
      rd(4'(4 + r), d); chk("R9 selectors untouched", d, map_word(r));
    end

    // R10 remap one source without disturbing another channel
    for (int s = 0; s < 32; s++) sel_s[s] = 15;
    sel_s[0] = 0; sel_s[1] = 2;
    for (int r = 0; r < 4; r++) wr(4'(4 + r), map_word(r));
    ena_s = 32'h3; wr(4'd0, ena_s);
    irq = 32'h3;
    @(negedge clk);
    chk("R10 before remap", 32'(ch), 32'h005);
    set_sel(1, 5);
    chk("R10 channel 0 held at write", 32'(ch[0]), 32'h1);
    @(negedge clk);
    chk("R10 after remap", 32'(ch), 32'h021);
    @(negedge clk);
    chk("R10 channel 0 still held", 32'(ch[0]), 32'h1);

    done = 1;
    summary();
  end
endmodule